// File: doc/BRIEF.md
# Processor Exception Control Unit

This block decides, once per retired instruction, whether a 32-bit core continues with its next sequential fetch or goes into exception processing. At each commit pulse it looks at six external interrupt request lines and at the synchronous events of the retiring instruction: illegal opcode, arithmetic overflow, system call, exception return, and an attempt to use a privileged operation. When it takes an exception, it tells fetch to redirect, supplies the fixed handler address, saves the interrupted PC and records a cause code. On exception return it redirects fetch to the saved PC.

The block holds three special registers. The saved PC register holds the PC of the interrupted flow. The cause word holds an exception code and a snapshot of the request lines. The status word holds an exception-level mask bit, the current privilege mode and the mode that was active before the last entry. Handler software reads and writes these registers through a small select/data port. Writes through this port are privileged, and so are I/O access and exception return. In user mode each of them turns into a privilege fault.

Top module: `trap_unit`

## Requirements
- R1: Requests and strobes are acted on only in a cycle where `commit_i` is 1. `redirect_o` is combinational and is high only in such a cycle.
- R2: On exception entry, `redirect_pc_o` is 0x80000180. At the next clock edge the saved PC register (select 0) takes the value of `pc_i`.
- R3: Any of the six request lines can cause entry, and the resulting cause word has code 0. Cause bits 15:10 hold the request lines sampled at entry, and bits 6:2 hold the code.
- R4: While the status level bit (bit 0) is 1, request lines cause no entry, even if they stay asserted.
- R5: An exception return at commit in kernel mode redirects to the saved PC. It clears the level bit and copies the prior-mode bit (bit 2) into the mode bit (bit 1).
- R6: A system call enters through the same handler address as an interrupt, with cause code 8.
- R7: An illegal instruction enters with cause code 10. An arithmetic overflow enters with cause code 12.
- R8: Status layout: bit 0 is the level, bit 1 is the mode (1 = kernel), bit 2 is the prior mode. On every entry the mode is copied into the prior mode, the mode is set to kernel and the level is set to 1.
- R9: In user mode, a register write, an I/O request or an exception return at commit raises cause code 11 and does not perform the operation.
- R10: At one commit the priority is: illegal, privilege, overflow, system call, exception return, interrupt. Synchronous events are taken even when the level bit is 1.
- R11: After reset the saved PC and the cause word are 0 and the status reads 6 (kernel mode, prior mode kernel, level 0).
- R12: Select 0 is the saved PC, 1 is cause, 2 is status and 3 reads 0. The read is combinational. A write takes effect at a kernel-mode commit that does not redirect. Writes to cause are ignored.
- R13: `io_ok_o` is high exactly when `io_req_i` is high and the mode is kernel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | 6 | External interrupt request lines |
| commit_i | input | 1 | End-of-instruction pulse |
| pc_i | input | 32 | PC of the retiring instruction |
| fault_illegal_i | input | 1 | Retiring instruction is illegal or unknown |
| fault_ovf_i | input | 1 | Retiring instruction overflowed |
| syscall_i | input | 1 | Retiring instruction is a system call |
| eret_i | input | 1 | Retiring instruction is an exception return |
| io_req_i | input | 1 | Retiring instruction accesses I/O |
| io_ok_o | output | 1 | I/O access permitted |
| csr_sel_i | input | 2 | Special register select |
| csr_we_i | input | 1 | Special register write request |
| csr_wdata_i | input | 32 | Special register write data |
| csr_rdata_o | output | 32 | Special register read data |
| redirect_o | output | 1 | Replace next sequential fetch |
| redirect_pc_o | output | 32 | New fetch address |
| kernel_o | output | 1 | Current mode is kernel |
| level_o | output | 1 | Exception level (interrupt mask) |

## Verification
The assertions assume that `pc_i` and the event strobes have meaning only in commit cycles and are stable for the whole cycle. They make no assumption about how many strobes are high at once, so overlapping faults, interrupts held through a handler, and returns issued in user mode are all legal input. The stimulus drives every input at the falling edge. It mixes directed sequences, which reach user mode through a status write followed by an exception return, with a long random phase that raises strobes in any combination and keeps request lines high for many cycles. A behavioural model is compared against the design on every cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int unsigned CODE_W   = 5;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned PEND_LSB = 10;

  typedef enum logic [CODE_W-1:0] {
    EC_INT  = 5'd0,
    EC_SYS  = 5'd8,
    EC_ILL  = 5'd10,
    EC_PRIV = 5'd11,
    EC_OVF  = 5'd12
  } exc_code_e;

  typedef enum logic [1:0] {
    SEL_EPC    = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } csr_sel_e;

  typedef struct packed {
    logic pkm;  // mode before last entry
    logic km;   // 1 = kernel
    logic exl;  // exception level
  } status_t;

  localparam status_t STATUS_RST = '{pkm: 1'b1, km: 1'b1, exl: 1'b0};

  // Fixed priority among synchronous events.
  function automatic exc_code_e pick_code(logic ill, logic priv, logic ovf, logic sys);
    if (ill)       return EC_ILL;
    else if (priv) return EC_PRIV;
    else if (ovf)  return EC_OVF;
    else if (sys)  return EC_SYS;
    else           return EC_INT;
  endfunction

  function automatic status_t status_on_entry(status_t s);
    status_t n;
    n.pkm = s.km;
    n.km  = 1'b1;
    n.exl = 1'b1;
    return n;
  endfunction

  function automatic status_t status_on_return(status_t s);
    status_t n;
    n.pkm = s.pkm;
    n.km  = s.pkm;
    n.exl = 1'b0;
    return n;
  endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int unsigned NIRQ = 6
) (
  input  logic            commit_i,
  input  logic [NIRQ-1:0] irq_i,
  input  status_t         st_i,
  input  logic            ill_i,
  input  logic            ovf_i,
  input  logic            sys_i,
  input  logic            eret_i,
  input  logic            csr_we_i,
  input  logic            io_req_i,
  output logic            take_sync_o,
  output logic            take_irq_o,
  output logic            take_eret_o,
  output logic            csr_wr_ok_o,
  output exc_code_e       code_o
);

  logic [NIRQ-1:0] live_irq;
  logic            priv_bad;
  logic            any_sync;

  genvar g;
  generate
    for (g = 0; g < NIRQ; g++) begin : g_mask
      assign live_irq[g] = irq_i[g] & ~st_i.exl;
    end
  endgenerate

  assign priv_bad = ~st_i.km & (csr_we_i | io_req_i | eret_i);
  assign any_sync = ill_i | priv_bad | ovf_i | sys_i;

  always_comb begin
    take_sync_o = commit_i & any_sync;
    take_eret_o = commit_i & ~any_sync & eret_i & st_i.km;
    take_irq_o  = commit_i & ~any_sync & ~eret_i & (|live_irq);
    csr_wr_ok_o = commit_i & csr_we_i & st_i.km
                  & ~take_sync_o & ~take_eret_o & ~take_irq_o;
    code_o      = take_sync_o ? pick_code(ill_i, priv_bad, ovf_i, sys_i) : EC_INT;
  end

endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NIRQ = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter_i,
  input  logic            leave_i,
  input  logic            wr_i,
  input  logic [1:0]      sel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] pc_i,
  input  exc_code_e       code_i,
  input  logic [NIRQ-1:0] irq_i,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o,
  output status_t         st_o
);

  localparam int unsigned ST_W = $bits(status_t);

  logic [XLEN-1:0] epc_q;
  exc_code_e       code_q;
  logic [NIRQ-1:0] pend_q;
  status_t         st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q  <= '0;
      code_q <= EC_INT;
      pend_q <= '0;
      st_q   <= STATUS_RST;
    end else if (enter_i) begin
      epc_q  <= pc_i;
      code_q <= code_i;
      pend_q <= irq_i;
      st_q   <= status_on_entry(st_q);
    end else if (leave_i) begin
      st_q   <= status_on_return(st_q);
    end else if (wr_i) begin
      if (sel_i == SEL_EPC)    epc_q <= wdata_i;
      if (sel_i == SEL_STATUS) st_q  <= status_t'(wdata_i[ST_W-1:0]);
    end
  end

  always_comb begin
    cause_o = '0;
    cause_o[CODE_LSB +: CODE_W] = code_q;
    cause_o[PEND_LSB +: NIRQ]   = pend_q;
  end

  assign epc_o = epc_q;
  assign st_o  = st_q;

endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     NIRQ       = 6,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            commit_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            fault_illegal_i,
  input  logic            fault_ovf_i,
  input  logic            syscall_i,
  input  logic            eret_i,
  input  logic            io_req_i,
  output logic            io_ok_o,
  input  logic [1:0]      csr_sel_i,
  input  logic            csr_we_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            kernel_o,
  output logic            level_o
);

  localparam int unsigned ST_W = $bits(status_t);

  logic            take_sync;
  logic            take_irq;
  logic            take_eret;
  logic            take_exc;
  logic            csr_wr_ok;
  exc_code_e       code;
  status_t         st;
  logic            st_pkm;
  logic [XLEN-1:0] epc_q;
  logic [XLEN-1:0] cause_q;

  trap_arbiter #(.NIRQ(NIRQ)) u_arb (
    .commit_i    (commit_i),
    .irq_i       (irq_i),
    .st_i        (st),
    .ill_i       (fault_illegal_i),
    .ovf_i       (fault_ovf_i),
    .sys_i       (syscall_i),
    .eret_i      (eret_i),
    .csr_we_i    (csr_we_i),
    .io_req_i    (io_req_i),
    .take_sync_o (take_sync),
    .take_irq_o  (take_irq),
    .take_eret_o (take_eret),
    .csr_wr_ok_o (csr_wr_ok),
    .code_o      (code)
  );

  assign take_exc = take_sync | take_irq;

  trap_regs #(.XLEN(XLEN), .NIRQ(NIRQ)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter_i (take_exc),
    .leave_i (take_eret),
    .wr_i    (csr_wr_ok),
    .sel_i   (csr_sel_i),
    .wdata_i (csr_wdata_i),
    .pc_i    (pc_i),
    .code_i  (code),
    .irq_i   (irq_i),
    .epc_o   (epc_q),
    .cause_o (cause_q),
    .st_o    (st)
  );

  assign st_pkm = st.pkm;

  always_comb begin
    unique case (csr_sel_i)
      SEL_EPC:    csr_rdata_o = epc_q;
      SEL_CAUSE:  csr_rdata_o = cause_q;
      SEL_STATUS: csr_rdata_o = {{(XLEN-ST_W){1'b0}}, st};
      default:    csr_rdata_o = '0;
    endcase
  end

  assign redirect_o    = take_exc | take_eret;
  assign redirect_pc_o = take_exc ? HANDLER_PC : epc_q;
  assign kernel_o      = st.km;
  assign level_o       = st.exl;
  assign io_ok_o       = io_req_i & st.km;

endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
  input logic            clk,
  input logic            rst_n,
  input logic            commit_i,
  input logic [XLEN-1:0] pc_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            kernel_o,
  input logic            level_o,
  input logic            take_exc,
  input logic            take_irq,
  input logic            take_eret,
  input logic [XLEN-1:0] epc_q,
  input logic            st_pkm
);

  AST_REDIRECT_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> commit_i); // R1

  AST_HANDLER_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> redirect_pc_o == HANDLER_PC); // R2

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> epc_q == $past(pc_i)); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    level_o |-> !take_irq); // R4

  AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> kernel_o && level_o); // R8

  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    take_eret |-> redirect_pc_o == epc_q); // R5

  AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    take_eret |=> !level_o && (kernel_o == $past(st_pkm))); // R5

endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .commit_i      (commit_i),
  .pc_i          (pc_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .kernel_o      (kernel_o),
  .level_o       (level_o),
  .take_exc      (take_exc),
  .take_irq      (take_irq),
  .take_eret     (take_eret),
  .epc_q         (epc_q),
  .st_pkm        (st_pkm)
);

// File: tb/tb_trap_unit.sv
module tb_trap_unit;

  localparam logic [31:0] HADDR = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  irq;
  logic        commit, ill, ovf, sys, eret, io_req, csr_we;
  logic [31:0] pc, wdata;
  logic [1:0]  sel;
  logic        io_ok, redirect, kernel, level;
  logic [31:0] rdata, rpc;

  always #5 clk = ~clk;

  trap_unit dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .commit_i(commit), .pc_i(pc),
    .fault_illegal_i(ill), .fault_ovf_i(ovf), .syscall_i(sys), .eret_i(eret),
    .io_req_i(io_req), .io_ok_o(io_ok), .csr_sel_i(sel), .csr_we_i(csr_we),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .redirect_o(redirect),
    .redirect_pc_o(rpc), .kernel_o(kernel), .level_o(level)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_epc;
  int          m_code;
  logic [5:0]  m_pend;
  bit          m_exl, m_km, m_pkm;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    commit = 0; ill = 0; ovf = 0; sys = 0; eret = 0; io_req = 0; csr_we = 0;
    wdata = '0;
  endtask

  function automatic logic [31:0] model_read(logic [1:0] s);
    case (s)
      2'd0: return m_epc;
      2'd1: return (32'(m_pend) << 10) | (32'(m_code) << 2);
      2'd2: return {29'd0, m_pkm, m_km, m_exl};
      default: return 32'd0;
    endcase
  endfunction

  // Inputs already driven after a falling edge; compare, then advance one cycle.
  task automatic cycle();
    bit pu, sync, take, er, wr;
    int code;
    #1;
    pu   = !m_km && (csr_we || io_req || eret);
    sync = ill || pu || ovf || sys;
    take = 0; er = 0; wr = 0; code = 0;
    if (commit && sync) begin
      take = 1;
      code = ill ? 10 : pu ? 11 : ovf ? 12 : 8;
    end else if (commit && eret) er = 1;
    else if (commit && !m_exl && (|irq)) take = 1;
    else wr = commit && csr_we;
    chk(sync ? "R10 redirect" : "R1 redirect", 32'(redirect), 32'(take || er));
    if (take || er) chk(take ? "R2 target" : "R5 target", rpc, take ? HADDR : m_epc);
    chk("R8 kernel", 32'(kernel), 32'(m_km));
    chk("R4 level", 32'(level), 32'(m_exl));
    chk("R12 read", rdata, model_read(sel));
    chk("R13 io", 32'(io_ok), 32'(io_req && m_km));
    @(posedge clk);
    if (take) begin
      m_epc = pc; m_code = code; m_pend = irq;
      m_pkm = m_km; m_km = 1; m_exl = 1;
    end else if (er) begin
      m_km = m_pkm; m_exl = 0;
    end else if (wr) begin
      if (sel == 2'd0) m_epc = wdata;
      if (sel == 2'd2) {m_pkm, m_km, m_exl} = wdata[2:0];
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq = '0; pc = '0; sel = 2'd0; idle();
    m_epc = '0; m_code = 0; m_pend = '0; m_exl = 0; m_km = 1; m_pkm = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    sel = 2'd2; #1 chk("R11 status", rdata, 32'h6); cycle();
    sel = 2'd1; #1 chk("R11 cause", rdata, 32'h0); cycle();
    sel = 2'd0; #1 chk("R11 epc", rdata, 32'h0); cycle();

    // R1 request without commit
    irq = 6'b000100; #1 chk("R1 no commit", 32'(redirect), 0); cycle();

    // R3 interrupt entry
    commit = 1; pc = 32'h0040_0010;
    #1 chk("R3 entry", 32'(redirect), 1); chk("R2 handler", rpc, HADDR); cycle();
    idle(); sel = 2'd1; #1 chk("R3 cause", rdata, 32'h0000_1000); cycle();
    sel = 2'd0; #1 chk("R2 saved pc", rdata, 32'h0040_0010); cycle();
    sel = 2'd2; #1 chk("R8 status", rdata, 32'h7); cycle();

    // R4 held request is masked
    commit = 1; pc = HADDR;
    #1 chk("R4 masked", 32'(redirect), 0); cycle();
    irq = '0;

    // status write: prior mode user, level kept
    commit = 1; csr_we = 1; sel = 2'd2; wdata = 32'h3; cycle();
    idle();
    // R5 return
    commit = 1; eret = 1;
    #1 chk("R5 redirect", 32'(redirect), 1); chk("R5 target", rpc, 32'h0040_0010); cycle();
    idle(); sel = 2'd2;
    #1 chk("R5 status", rdata, 32'h0); chk("R5 user", 32'(kernel), 0); cycle();

    // R9 privileged write in user mode
    commit = 1; csr_we = 1; sel = 2'd0; wdata = 32'h1234; pc = 32'h0040_0100;
    #1 chk("R9 trap", 32'(redirect), 1); cycle();
    idle(); sel = 2'd0; #1 chk("R9 not written", rdata, 32'h0040_0100); cycle();
    sel = 2'd1; #1 chk("R9 code", rdata, 32'h2C); cycle();
    sel = 2'd2; #1 chk("R8 entry from user", rdata, 32'h3); cycle();

    // R6 syscall while level set (R10 sync not masked)
    commit = 1; sys = 1; pc = 32'h8000_0200;
    #1 chk("R6 redirect", 32'(redirect), 1); chk("R6 target", rpc, HADDR); cycle();
    idle(); sel = 2'd1; #1 chk("R6 code", rdata, 32'h20); cycle();

    // R10 priority: all at once
    commit = 1; ill = 1; ovf = 1; sys = 1; irq = 6'b100001; pc = 32'h8000_0300; cycle();
    idle(); irq = '0; sel = 2'd1; #1 chk("R10 code", rdata, 32'h0000_8428); cycle();

    // R7 overflow alone
    commit = 1; ovf = 1; cycle();
    idle(); sel = 2'd1; #1 chk("R7 code", rdata, 32'h30); cycle();

    // R12 cause ignores writes
    commit = 1; csr_we = 1; sel = 2'd1; wdata = 32'hFFFF_FFFF; cycle();
    idle(); sel = 2'd1; #1 chk("R12 cause held", rdata, 32'h30); cycle();
    sel = 2'd3; #1 chk("R12 unused sel", rdata, 32'h0); cycle();

    // R13 I/O permission in kernel mode
    io_req = 1; #1 chk("R13 io kernel", 32'(io_ok), 1); cycle();
    idle();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(9) == 0) irq = 6'($urandom);
      commit = ($urandom_range(1) == 1);
      ill    = ($urandom_range(19) == 0);
      ovf    = ($urandom_range(19) == 0);
      sys    = ($urandom_range(19) == 0);
      eret   = ($urandom_range(9) == 0);
      io_req = ($urandom_range(14) == 0);
      csr_we = ($urandom_range(7) == 0);
      sel    = 2'($urandom);
      wdata  = $urandom;
      pc     = {$urandom} & 32'hFFFF_FFFC;
      cycle();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule